// File: doc/BRIEF.md
# Panel Row and Frame Timing Generator

This block paces the rows and frames of a thin-film panel driver. In internal mode it divides the oscillator clock by 1, 2, 4 or 8 to make an operating tick. In dot-clock mode it takes its tick straight from a dot-clock enable and ignores the divider. A fixed number of ticks makes one row. A frame is the active lines plus the rows of both porches. The block reports each row start and each frame start with a one-cycle strobe, and it keeps a row index.

At every row boundary the block can raise an equalize level for a short run of ticks. The length comes from a 2-bit code, and what that code means depends on the interface mode. The level is gated by the polarity-alternation enable. All timing settings are captured together when a frame begins, so the rows of one frame always share one set of settings.

Everything runs on the oscillator clock `clk`. The dot clock arrives as a synchronous one-cycle enable, `dot_tick`. The block only has control and status pins and carries no data stream, so it has no valid/ready handshake.

Top module: `lcd_row_timer`

## Requirements
- R1: In internal mode (`rgb_mode`=0), `div_code` 0, 1, 2 and 3 make one tick every 1, 2, 4 and 8 `clk` cycles. A row with C ticks therefore lasts C·2^div_code cycles.
- R2: A row lasts `row_clks` ticks, and a value of 0 is taken as 1.
- R3: A frame holds T = `line_count` + `bp_rows` + `fp_rows` rows, and a total of 0 is taken as 1. `row_index` reads 0, 1, …, T−1 at successive row strobes.
- R4: In dot-clock mode (`rgb_mode`=1), one tick is taken per cycle with `dot_tick` high, and `div_code` has no effect.
- R5: In internal mode, `eq_code` 0, 1, 2 and 3 give equalize lengths of 0, 1, 2 and 3 ticks.
- R6: In dot-clock mode, `eq_code` 0, 1, 2 and 3 give equalize lengths of 0, 8, 16 and 24 ticks.
- R7: `equalize` is high only while `ac_en` is high, whatever the code.
- R8: `equalize` rises with the row strobe. It stays high for min(length, C−1) ticks, where C is the effective row length, so every row keeps at least one tick with it low.
- R9: `div_code`, `row_clks`, `line_count`, `bp_rows`, `fp_rows`, `eq_code` and `rgb_mode` are sampled only at a frame start. A change made during a frame takes effect from the next frame.
- R10: A synchronous active-low reset clears the divider, the tick counter and the row counter. While reset is low, and one cycle after it, all strobes and `equalize` are low. The first tick after reset starts frame row 0.
- R11: `row_strobe` is a one-cycle pulse at each row start. `frame_strobe` pulses together with the row strobe of row 0, and `row_index` is 0 at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_code | input | 2 | Divider select, ratio 2^div_code |
| row_clks | input | CPR_W | Ticks per row |
| line_count | input | LINE_W | Active lines |
| bp_rows | input | PORCH_W | Back-porch rows |
| fp_rows | input | PORCH_W | Front-porch rows |
| eq_code | input | 2 | Equalize length code |
| ac_en | input | 1 | Polarity-alternation enable, gates equalize |
| rgb_mode | input | 1 | 0 internal divided clock, 1 dot-clock enable |
| dot_tick | input | 1 | Dot-clock enable, one cycle per dot |
| row_strobe | output | 1 | One-cycle pulse at a row start |
| frame_strobe | output | 1 | One-cycle pulse at the start of row 0 |
| row_index | output | ROW_W | Current row of the frame |
| equalize | output | 1 | Equalize level at the start of a row |

## Verification
The assertions assume that `rst_n` is low at time zero and that `ac_en` does not rise in the middle of a row while the tick counter is already inside the equalize window. The bench meets this by holding `ac_en` constant over each measured frame. It changes settings only at the negative clock edge, and `dot_tick` comes from a free-running counter with a period of three cycles.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

  typedef enum logic {
    TIM_INTERNAL = 1'b0,
    TIM_DOTCLK   = 1'b1
  } tim_mode_e;

  // Equalize length in ticks for a code and interface mode.
  function automatic int unsigned eq_ticks(input logic [1:0] code, input tim_mode_e mode);
    int unsigned n;
    n = int'(code);
    return (mode == TIM_DOTCLK) ? (n * 8) : n;
  endfunction

endpackage

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rgb,
  input  logic [DIV_W-1:0] div_code,
  input  logic             restart,
  input  logic             dot_tick,
  output logic             tick
);
  localparam int MAX_SHIFT = (1 << DIV_W) - 1;
  localparam int CNT_W     = MAX_SHIFT + 1;

  logic [CNT_W-1:0] div_cnt;
  logic [CNT_W-1:0] ratio_m1;

  assign ratio_m1 = CNT_W'((1 << div_code) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (restart || rgb) begin
      div_cnt <= '0;
    end else if (div_cnt == ratio_m1) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign tick = rgb ? dot_tick : (div_cnt == ratio_m1);

endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq #(
  parameter int CPR_W = 6,
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CPR_W-1:0] cpr,
  input  logic [ROW_W-1:0] total_rows,
  output logic [CPR_W-1:0] clk_cnt,
  output logic [ROW_W-1:0] row_cnt,
  output logic             running,
  output logic             row_start,
  output logic             frame_start
);
  logic [CPR_W-1:0] cpr_last;
  logic [ROW_W-1:0] row_last;
  logic             row_end;

  assign cpr_last    = (cpr == '0) ? '0 : cpr - 1'b1;
  assign row_last    = (total_rows == '0) ? '0 : total_rows - 1'b1;
  assign row_end     = (clk_cnt == cpr_last);
  assign frame_start = tick && (!running || (row_end && row_cnt == row_last));
  assign row_start   = tick && (!running || row_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_cnt <= '0;
      row_cnt <= '0;
      running <= 1'b0;
    end else if (tick) begin
      if (frame_start) begin
        clk_cnt <= '0;
        row_cnt <= '0;
        running <= 1'b1;
      end else if (row_end) begin
        clk_cnt <= '0;
        row_cnt <= row_cnt + 1'b1;
      end else begin
        clk_cnt <= clk_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_eq_gen.sv
module lcd_eq_gen
  import lcd_tim_pkg::*;
#(
  parameter int CPR_W = 6
) (
  input  tim_mode_e        mode,
  input  logic [1:0]       eq_code,
  input  logic [CPR_W-1:0] cpr,
  input  logic [CPR_W-1:0] clk_cnt,
  input  logic             running,
  input  logic             ac_en,
  output logic             equalize
);
  int unsigned len;
  int unsigned cap;
  int unsigned lim;

  always_comb begin
    len = eq_ticks(eq_code, mode);
    cap = (cpr == '0) ? 0 : int'(cpr) - 1;
    lim = (len < cap) ? len : cap;
    equalize = running && ac_en && (int'(clk_cnt) < lim);
  end

endmodule

// File: rtl/lcd_row_timer.sv
module lcd_row_timer
  import lcd_tim_pkg::*;
#(
  parameter int CPR_W   = 6,
  parameter int LINE_W  = 9,
  parameter int PORCH_W = 4,
  localparam int ROW_W  = ((LINE_W > PORCH_W) ? LINE_W : PORCH_W) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         div_code,
  input  logic [CPR_W-1:0]   row_clks,
  input  logic [LINE_W-1:0]  line_count,
  input  logic [PORCH_W-1:0] bp_rows,
  input  logic [PORCH_W-1:0] fp_rows,
  input  logic [1:0]         eq_code,
  input  logic               ac_en,
  input  logic               rgb_mode,
  input  logic               dot_tick,
  output logic               row_strobe,
  output logic               frame_strobe,
  output logic [ROW_W-1:0]   row_index,
  output logic               equalize
);
  typedef struct packed {
    logic [1:0]         div;
    logic [CPR_W-1:0]   cpr;
    logic [ROW_W-1:0]   total;
    logic [1:0]         eq;
    tim_mode_e          mode;
  } tim_cfg_t;

  tim_cfg_t         cfg_live, cfg;
  logic             tick, row_start, frame_start, running;
  logic [CPR_W-1:0] clk_cnt;
  logic [ROW_W-1:0] row_cnt;

  always_comb begin
    cfg_live.div   = div_code;
    cfg_live.cpr   = row_clks;
    cfg_live.total = ROW_W'(line_count) + ROW_W'(bp_rows) + ROW_W'(fp_rows);
    cfg_live.eq    = eq_code;
    cfg_live.mode  = rgb_mode ? TIM_DOTCLK : TIM_INTERNAL;
  end

  // Settings captured only at frame start
  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) begin
      cfg <= cfg_live;
    end
  end

  lcd_tick_gen #(.DIV_W(2)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .rgb      (cfg.mode == TIM_DOTCLK),
    .div_code (cfg.div),
    .restart  (frame_start),
    .dot_tick (dot_tick),
    .tick     (tick)
  );

  lcd_row_seq #(.CPR_W(CPR_W), .ROW_W(ROW_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .cpr         (cfg.cpr),
    .total_rows  (cfg.total),
    .clk_cnt     (clk_cnt),
    .row_cnt     (row_cnt),
    .running     (running),
    .row_start   (row_start),
    .frame_start (frame_start)
  );

  lcd_eq_gen #(.CPR_W(CPR_W)) u_eq (
    .mode     (cfg.mode),
    .eq_code  (cfg.eq),
    .cpr      (cfg.cpr),
    .clk_cnt  (clk_cnt),
    .running  (running),
    .ac_en    (ac_en),
    .equalize (equalize)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_strobe   <= 1'b0;
      frame_strobe <= 1'b0;
    end else begin
      row_strobe   <= row_start;
      frame_strobe <= frame_start;
    end
  end

  assign row_index = row_cnt;

endmodule

// File: rtl/lcd_row_timer_chk.sv
module lcd_row_timer_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ac_en,
  input logic             row_strobe,
  input logic             frame_strobe,
  input logic [ROW_W-1:0] row_index,
  input logic             equalize
);
  // R7: equalize only under AC drive
  p_eq_needs_ac_r7: assert property (@(posedge clk) disable iff (!rst_n)
    equalize |-> ac_en);

  // R11: frame strobe coincides with a row strobe at row 0
  p_frame_row0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> (row_strobe && row_index == '0));

  // R3: a row strobe inside a frame advances the index by one
  p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (row_strobe && !frame_strobe) |-> (row_index == $past(row_index) + 1'b1));

  // R8: equalize rises only at a row start
  p_eq_at_row_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(equalize) && $past(ac_en)) |-> row_strobe);

  // R10: outputs quiet one cycle after a reset cycle
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> (!row_strobe && !frame_strobe && !equalize));

endmodule

bind lcd_row_timer lcd_row_timer_chk #(.ROW_W(ROW_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ac_en        (ac_en),
  .row_strobe   (row_strobe),
  .frame_strobe (frame_strobe),
  .row_index    (row_index),
  .equalize     (equalize)
);

// File: tb/tb_lcd_row_timer.sv
module tb_lcd_row_timer;
  localparam int CPR_W = 6, LINE_W = 9, PORCH_W = 4;
  localparam int ROW_W = LINE_W + 2;
  localparam int DOT_P = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] div_code = '0, eq_code = '0;
  logic [CPR_W-1:0] row_clks = 6'd3;
  logic [LINE_W-1:0] line_count = 9'd2;
  logic [PORCH_W-1:0] bp_rows = 4'd1, fp_rows = 4'd1;
  logic ac_en = 1'b1, rgb_mode = 1'b0, dot_tick = 1'b0;
  logic row_strobe, frame_strobe, equalize;
  logic [ROW_W-1:0] row_index;

  int n_chk = 0, n_fail = 0, dcnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    dcnt     <= (dcnt == DOT_P - 1) ? 0 : dcnt + 1;
    dot_tick <= (dcnt == DOT_P - 1);
  end

  lcd_row_timer #(.CPR_W(CPR_W), .LINE_W(LINE_W), .PORCH_W(PORCH_W)) dut (
    .clk(clk), .rst_n(rst_n), .div_code(div_code), .row_clks(row_clks),
    .line_count(line_count), .bp_rows(bp_rows), .fp_rows(fp_rows),
    .eq_code(eq_code), .ac_en(ac_en), .rgb_mode(rgb_mode), .dot_tick(dot_tick),
    .row_strobe(row_strobe), .frame_strobe(frame_strobe),
    .row_index(row_index), .equalize(equalize));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Wait for a fresh frame strobe (sampled at negedge)
  task automatic wait_frame();
    @(negedge clk);
    while (!frame_strobe) @(negedge clk);
  endtask

  // Starting at a frame strobe sample, measure until the next one
  task automatic measure(output int cyc, output int rows, output int eqc, output int idx_err);
    cyc = 1; rows = 0; eqc = 0; idx_err = 0;
    forever begin
      if (row_strobe) begin
        if (int'(row_index) != rows) idx_err++;
        rows++;
      end
      if (equalize) eqc++;
      @(negedge clk);
      if (frame_strobe) break;
      cyc++;
    end
  endtask

  task automatic run_cfg(input string tag, input int exp_cyc, input int exp_rows, input int exp_eq);
    int cyc, rows, eqc, ierr;
    wait_frame();
    measure(cyc, rows, eqc, ierr);
    chk(cyc == exp_cyc, {tag, " frame period"}, cyc, exp_cyc);
    chk(rows == exp_rows, {tag, " rows per frame R3"}, rows, exp_rows);
    chk(eqc == exp_eq, {tag, " equalize cycles"}, eqc, exp_eq);
    chk(ierr == 0, {tag, " row index sequence R3 R11"}, ierr, 0);
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    int cyc, rows, eqc, ierr;
    repeat (3) begin
      @(negedge clk);
      chk(!row_strobe && !frame_strobe && !equalize, "R10 reset outputs",
          int'({row_strobe, frame_strobe, equalize}), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_strobe && row_index == 0, "R10 first tick starts row 0", int'(frame_strobe), 1);

    // R1 R2 R5 R8: internal sweep
    for (int d = 0; d < 4; d++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int e = 0; e < 4; e++) begin
          int c, r;
          c = (ci == 0) ? 3 : 5; r = 1 << d;
          div_code = 2'(d); row_clks = CPR_W'(c); eq_code = 2'(e);
          run_cfg("R1 R2 R5 R8 internal", c * r * 4, 4, 4 * imin(e, c - 1) * r);
        end
      end
    end

    // R2: zero row length treated as one tick
    div_code = 2'd0; row_clks = '0; eq_code = 2'd3;
    run_cfg("R2 zero row length", 4, 4, 0);

    // R3: zero total treated as one row
    row_clks = 6'd3; line_count = '0; bp_rows = '0; fp_rows = '0; eq_code = 2'd1;
    run_cfg("R3 zero rows", 3, 1, 1);

    // R7: no equalize without AC drive
    line_count = 9'd2; bp_rows = 4'd1; fp_rows = 4'd1;
    row_clks = 6'd5; eq_code = 2'd3; ac_en = 1'b0;
    run_cfg("R7 ac off", 20, 4, 0);
    ac_en = 1'b1;

    // R4 R6: dot-clock mode, divider setting ignored
    rgb_mode = 1'b1; div_code = 2'd3; row_clks = 6'd30;
    line_count = 9'd1; bp_rows = 4'd0; fp_rows = 4'd1;
    for (int e = 0; e < 4; e++) begin
      eq_code = 2'(e);
      run_cfg("R4 R6 dot-clock", DOT_P * 30 * 2, 2, 2 * imin(8 * e, 29) * DOT_P);
    end

    // R9: mid-frame change applies to the next frame only
    rgb_mode = 1'b0; div_code = 2'd0; row_clks = 6'd4;
    line_count = 9'd2; bp_rows = 4'd1; fp_rows = 4'd1; eq_code = 2'd0;
    wait_frame();
    wait_frame();
    div_code = 2'd1; row_clks = 6'd5;
    measure(cyc, rows, eqc, ierr);
    chk(cyc == 16, "R9 current frame keeps old settings", cyc, 16);
    measure(cyc, rows, eqc, ierr);
    chk(cyc == 40, "R9 next frame uses new settings", cyc, 40);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule